// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block joins two data ports, A and B, through two independent one-way paths. Each path has its own storage element. That element works as a transparent latch while its latch-enable is high. While latch-enable is low, it holds its value until the path's own clock input makes a low-to-high transition, and then it loads the current input. Each path also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs synchronously on a free-running system clock. Each direction clock is treated as an asynchronous strobe. It passes through a synchronizer chain and an edge detector, so only a detected rising edge can load the storage. A steady high level never does. Each data input has a bus keeper. When the far side stops driving a port, the keeper supplies the last value that was driven. Each output is modelled as a data vector plus a drive-enable bit. The enclosing chip decides how to build the physical tri-state pad.

If both directions drive at once, a registered contention flag is raised. Both ports keep driving as commanded.

Top module: `ubr_bus_register`

## Requirements
- R1: Both data paths are `DATA_W` bits wide (default 18). Controls and data of one direction never change the other direction's output.
- R2: While a direction's latch-enable is high, its storage loads the input on every system clock edge. The output equals the input one system cycle later.
- R3: While latch-enable is low and the direction clock is steady (high or low), the stored value is held.
- R4: While latch-enable is low, a low-to-high transition of the direction clock loads the input. With the default 2-stage synchronizer, the new value appears on the output after the third system clock edge that follows the transition.
- R5: A falling direction clock or a static high level never causes a load. If latch-enable falls while the direction clock is already high, the value stored last is held.
- R6: Output enables are registered with one cycle of latency. `ab_out_en` = 1 makes `b_drive` = 1, and `ba_out_en_n` = 0 makes `a_drive` = 1. When a drive bit is 0, that port is released (high impedance).
- R7: `contention` goes to 1 one cycle after both drive bits would be 1. Both ports keep driving while the flag is set.
- R8: When `a_driven` (or `b_driven`) is 0, the keeper supplies the last value seen on that port while it was driven, and the value currently on the undriven input is ignored.
- R9: A synchronous active-high reset clears both storage registers, both keepers, both drive bits and `contention` to 0.
- R10: The B-to-A path behaves exactly like the A-to-B path (R2 to R5), using `ba_latch_en`, `ba_clk` and `b_in`/`b_driven`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DATA_W | Value seen on port A |
| a_driven | input | 1 | 1 when an external source drives port A |
| b_in | input | DATA_W | Value seen on port B |
| b_driven | input | 1 | 1 when an external source drives port B |
| ab_latch_en | input | 1 | A-to-B transparent select |
| ab_clk | input | 1 | A-to-B capture strobe (asynchronous) |
| ab_out_en | input | 1 | A-to-B output enable, active high |
| ba_latch_en | input | 1 | B-to-A transparent select |
| ba_clk | input | 1 | B-to-A capture strobe (asynchronous) |
| ba_out_en_n | input | 1 | B-to-A output enable, active low |
| a_out | output | DATA_W | Data driven onto port A |
| a_drive | output | 1 | Port A driver on |
| b_out | output | DATA_W | Data driven onto port B |
| b_drive | output | 1 | Port B driver on |
| contention | output | 1 | Both drivers on at once |

## Verification
The bench builds the block with its defaults: 18-bit data and a 2-stage synchronizer. The full-width all-ones, alternating and single-bit patterns therefore reach every bit, and the capture latency is the fixed three system edges named in R4. With two stages, the gap between a strobe level change and its effect is short enough to walk every mode from one table. That table covers the rising-edge load, the falling-edge and high-level non-loads, and latch-enable falling with the strobe high. Directed steps then cover the reverse path, the contention overlap and reset in the middle of a run.

// File: rtl/ubr_pkg.sv
`timescale 1ns/1ps
package ubr_pkg;
    localparam int unsigned DATA_W      = 18;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic latch_en;
        logic dir_clk;
        logic oe_raw;
    } lane_ctrl_t;

    function automatic logic enable_level(input logic raw, input bit active_low);
        return active_low ? ~raw : raw;
    endfunction
endpackage

// File: rtl/ubr_edge_detect.sv
`timescale 1ns/1ps
module ubr_edge_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/ubr_keeper.sv
`timescale 1ns/1ps
module ubr_keeper #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_val,
    input  logic         bus_driven,
    output logic [W-1:0] kept
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)             held <= '0;
        else if (bus_driven) held <= bus_val;
    end

    assign kept = bus_driven ? bus_val : held;

    // R8
    keeper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_driven |=> $stable(held));
endmodule

// File: rtl/ubr_store.sv
`timescale 1ns/1ps
module ubr_store #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         latch_en,
    input  logic         rise,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)                  q <= '0;
        else if (latch_en || rise) q <= d;
    end

    // R2
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        latch_en |=> q == $past(d));

    // R3
    static_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !rise) |=> $stable(q));
endmodule

// File: rtl/ubr_lane.sv
`timescale 1ns/1ps
module ubr_lane
    import ubr_pkg::*;
#(
    parameter int unsigned W             = 18,
    parameter int unsigned STAGES        = 2,
    parameter bit          OE_ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_val,
    input  logic         in_driven,
    input  lane_ctrl_t   ctrl,
    output logic [W-1:0] out_val,
    output logic         out_en
);
    logic [W-1:0] kept;
    logic         rise;

    ubr_keeper #(.W(W)) u_keeper (
        .clk(clk), .rst(rst), .bus_val(in_val), .bus_driven(in_driven), .kept(kept)
    );

    ubr_edge_detect #(.STAGES(STAGES)) u_edge (
        .clk(clk), .rst(rst), .async_in(ctrl.dir_clk), .rise(rise)
    );

    ubr_store #(.W(W)) u_store (
        .clk(clk), .rst(rst), .latch_en(ctrl.latch_en), .rise(rise), .d(kept), .q(out_val)
    );

    always_ff @(posedge clk) begin
        if (rst) out_en <= 1'b0;
        else     out_en <= enable_level(ctrl.oe_raw, OE_ACTIVE_LOW);
    end
endmodule

// File: rtl/ubr_bus_register.sv
`timescale 1ns/1ps
module ubr_bus_register
    import ubr_pkg::*;
#(
    parameter int unsigned DATA_W      = ubr_pkg::DATA_W,
    parameter int unsigned SYNC_STAGES = ubr_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic              a_driven,
    input  logic [DATA_W-1:0] b_in,
    input  logic              b_driven,
    input  logic              ab_latch_en,
    input  logic              ab_clk,
    input  logic              ab_out_en,
    input  logic              ba_latch_en,
    input  logic              ba_clk,
    input  logic              ba_out_en_n,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drive,
    output logic              contention
);
    lane_ctrl_t ab_ctrl, ba_ctrl;

    assign ab_ctrl = '{latch_en: ab_latch_en, dir_clk: ab_clk, oe_raw: ab_out_en};
    assign ba_ctrl = '{latch_en: ba_latch_en, dir_clk: ba_clk, oe_raw: ba_out_en_n};

    ubr_lane #(.W(DATA_W), .STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b0)) u_lane_ab (
        .clk(clk), .rst(rst), .in_val(a_in), .in_driven(a_driven), .ctrl(ab_ctrl),
        .out_val(b_out), .out_en(b_drive)
    );

    ubr_lane #(.W(DATA_W), .STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b1)) u_lane_ba (
        .clk(clk), .rst(rst), .in_val(b_in), .in_driven(b_driven), .ctrl(ba_ctrl),
        .out_val(a_out), .out_en(a_drive)
    );

    always_ff @(posedge clk) begin
        if (rst) contention <= 1'b0;
        else     contention <= ab_out_en & ~ba_out_en_n;
    end

    // R7
    contention_chk: assert property (@(posedge clk) disable iff (rst)
        contention |-> (a_drive && b_drive));

    // R9
    reset_off_chk: assert property (@(posedge clk)
        rst |=> (!a_drive && !b_drive && !contention));

    // R6
    ab_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ab_out_en |=> b_drive);
endmodule

// File: tb/ubr_bus_register_tb.sv
`timescale 1ns/1ps
module ubr_bus_register_tb;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         a_driven, b_driven;
    logic         ab_latch_en, ab_clk, ab_out_en;
    logic         ba_latch_en, ba_clk, ba_out_en_n;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive, contention;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ubr_bus_register u_dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_driven(a_driven), .b_in(b_in), .b_driven(b_driven),
        .ab_latch_en(ab_latch_en), .ab_clk(ab_clk), .ab_out_en(ab_out_en),
        .ba_latch_en(ba_latch_en), .ba_clk(ba_clk), .ba_out_en_n(ba_out_en_n),
        .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive),
        .contention(contention)
    );

    // Fields: [40] latch_en, [39] strobe, [38] out_en, [37] driven,
    //         [36:19] a_in, [18:1] expected b_out, [0] expected b_drive
    localparam logic [40:0] TBL [0:11] = '{
        {1'b1,1'b0,1'b1,1'b1,18'h12345,18'h12345,1'b1}, // R2 transparent
        {1'b1,1'b0,1'b1,1'b1,18'h0ABCD,18'h0ABCD,1'b1}, // R2
        {1'b0,1'b0,1'b1,1'b1,18'h3FFFF,18'h0ABCD,1'b1}, // R3 low strobe hold
        {1'b0,1'b1,1'b1,1'b1,18'h3FFFF,18'h3FFFF,1'b1}, // R4 rising capture
        {1'b0,1'b1,1'b1,1'b1,18'h00001,18'h3FFFF,1'b1}, // R5 high level hold
        {1'b0,1'b0,1'b1,1'b1,18'h00001,18'h3FFFF,1'b1}, // R5 falling no load
        {1'b0,1'b1,1'b1,1'b1,18'h00001,18'h00001,1'b1}, // R4 second capture
        {1'b1,1'b1,1'b1,1'b1,18'h2AAAA,18'h2AAAA,1'b1}, // R2
        {1'b0,1'b1,1'b1,1'b1,18'h15555,18'h2AAAA,1'b1}, // R5 LE falls, strobe high
        {1'b1,1'b1,1'b1,1'b0,18'h00000,18'h15555,1'b1}, // R8 keeper
        {1'b1,1'b1,1'b0,1'b1,18'h00777,18'h00777,1'b0}, // R6 disable
        {1'b1,1'b1,1'b1,1'b1,18'h3C3C3,18'h3C3C3,1'b1}  // R6 re-enable
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0; a_driven = 1'b1; b_driven = 1'b1;
        ab_latch_en = 1'b1; ab_clk = 1'b0; ab_out_en = 1'b1;
        ba_latch_en = 1'b1; ba_clk = 1'b0; ba_out_en_n = 1'b0;
        a_in = 18'h3FFFF; b_in = 18'h3FFFF;
        settle();
        // R9 reset state with enables asserted
        check("R9 b_drive", 32'(b_drive), 0);
        check("R9 a_drive", 32'(a_drive), 0);
        check("R9 b_out", 32'(b_out), 0);
        check("R9 a_out", 32'(a_out), 0);
        check("R9 contention", 32'(contention), 0);

        ba_out_en_n = 1'b1;
        ba_latch_en = 1'b0;
        b_in = 18'h00000;
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            ab_latch_en = TBL[i][40];
            ab_clk      = TBL[i][39];
            ab_out_en   = TBL[i][38];
            a_driven    = TBL[i][37];
            a_in        = TBL[i][36:19];
            settle();
            check($sformatf("R2-R8 row %0d b_out", i), 32'(b_out), 32'(TBL[i][18:1]));
            check($sformatf("R6 row %0d b_drive", i), 32'(b_drive), 32'(TBL[i][0]));
            check($sformatf("R1 row %0d a_out untouched", i), 32'(a_out), 0);
        end

        // R10 reverse path transparent, R7 contention
        ba_latch_en = 1'b1; ba_out_en_n = 1'b0; b_in = 18'h1F0F0; b_driven = 1'b1;
        settle();
        check("R10 a_out transparent", 32'(a_out), 32'h1F0F0);
        check("R6 a_drive active low", 32'(a_drive), 1);
        check("R7 contention set", 32'(contention), 1);
        check("R7 b_drive kept", 32'(b_drive), 1);
        check("R1 b_out independent", 32'(b_out), 32'h3C3C3);

        // R10 reverse hold and capture
        ba_latch_en = 1'b0; b_in = 18'h00F0F;
        settle();
        check("R10 a_out hold", 32'(a_out), 32'h1F0F0);
        ba_clk = 1'b1;
        settle();
        check("R10 a_out capture", 32'(a_out), 32'h00F0F);

        // R6 reverse disable, R7 clears
        ba_out_en_n = 1'b1;
        settle();
        check("R6 a_drive off", 32'(a_drive), 0);
        check("R7 contention clear", 32'(contention), 0);

        // R9 reset in the middle of a run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 mid b_out", 32'(b_out), 0);
        check("R9 mid a_out", 32'(a_out), 0);
        check("R9 mid b_drive", 32'(b_drive), 0);
        rst = 1'b0;
        ab_latch_en = 1'b1; a_driven = 1'b0; a_in = 18'h12121;
        settle();
        check("R9 keeper cleared", 32'(b_out), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule